// File: doc/BRIEF.md
# Two-Pass 8x8 DCT/IDCT Engine

This block transforms one 8x8 tile of 16-bit samples that sits in a shared 32-bit word memory. It computes either the forward or the inverse two-dimensional DCT in orthonormal scaling, and it writes the result back into the same tile. The host places the tile at a word base address. It then pulses `start` for one cycle, with `idct_mode` choosing the direction. The engine first runs eight one-dimensional transforms across the rows. It then runs eight across the columns and signals completion with a one-cycle `fin` pulse.

Each one-dimensional transform loads eight values into eight 16-bit working registers. It then applies four fixed compute steps taken from a fast even/odd factorization, and stores eight results. The steps use eight-input sum/difference butterflies, four-input add/subtract networks and paired multiply-accumulate rotations. The rotations take signed Q1.14 constants and round to nearest. The inverse applies the transposed steps in reverse order.

Memory reads are combinational: the word at `mem_addr` is on `mem_rdata` in the same cycle. Addresses count 32-bit words. Row results are packed two to a word, so the column pass can fetch two samples per access.

Top module: `dct2d_engine`

## Requirements
- R1: After reset, `fin` is 0 and `mem_we` is 0, and the engine is idle until a `start` pulse arrives.
- R2: During the row pass, row r (0..7) is read in 8 consecutive cycles from words base+8r+c for c = 0..7 in increasing order. Only bits 15:0 of each word are used; bits 31:16 are ignored.
- R3: Each one-dimensional transform spends exactly 4 compute cycles with `mem_we` = 0 between its last load and its first store.
- R4: The row pass stores element k of row r to word base+8*(r/2)+k, k = 0..7 in order. The strobe `mem_be` is 01 (low half) for even r and 10 (high half) for odd r, and the 16-bit value appears in both halves of `mem_wdata`.
- R5: During the column pass, column c reads words base+8j+c for j = 0..3 in 4 consecutive cycles. Bits 15:0 hold row 2j and bits 31:16 hold row 2j+1.
- R6: The column pass stores output element (k, c) to word base+8k+c with `mem_be` = 11, for k = 0..7 in order. Bits 31:16 are the sign extension of bits 15:0.
- R7: With `idct_mode` = 0, output word base+8u+v holds the orthonormal forward 2-D DCT, with u as the vertical and v as the horizontal frequency, within 5 LSB.
- R8: With `idct_mode` = 1, output word base+8i+j holds the orthonormal inverse 2-D DCT of the coefficients at base+8u+v, within 5 LSB.
- R9: `fin` is high for exactly one cycle, in the cycle after the last column store, with `mem_we` = 0 in that cycle. A full run from the first read to the last store takes 288 cycles.
- R10: A `start` pulse while the engine is busy is ignored. The bus sequence continues unchanged and no second run follows `fin`.
- R11: `base_addr` and `idct_mode` are sampled only in the cycle `start` is accepted. Changing them during a run has no effect on the addresses or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform (accepted only when idle) |
| idct_mode | input | 1 | 0 = forward DCT, 1 = inverse DCT |
| base_addr | input | 32 | Word address of tile element (0,0) |
| mem_addr | output | 32 | Word address of the current access |
| mem_rdata | input | 32 | Read data for `mem_addr`, valid in the same cycle |
| mem_wdata | output | 32 | Write data |
| mem_we | output | 1 | Write enable |
| mem_be | output | 2 | Half-word strobe: bit 0 = bits 15:0, bit 1 = bits 31:16 |
| fin | output | 1 | One-cycle completion pulse |

## Verification
Several checks run on every cycle. `fin` must be a single-cycle pulse that follows a full-word store. Half-word stores must carry the same value in both halves, and full-word stores must be sign-extended. No write may occur while idle, and every access must fall inside the 64-word tile window, whose base stays fixed during a run. The numeric accuracy of both directions, the exact address order in each pass, the 4-cycle compute gap, and the rejection of a mid-run `start`, base or mode change can only be shown by the bench's scenarios. These compare the bus against an expected operation queue and the final tile against a real-valued transform.

// File: rtl/dct2d_pkg.sv
package dct2d_pkg;
    localparam int SAMP_W = 16;
    localparam int FRAC_W = 14;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef samp_t [7:0] bank_t;

    typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_CALC, PH_STORE} phase_e;
    typedef enum logic [2:0] {OP_BFLY, OP_STG2, OP_STG3, OP_ROT4, OP_IROT4, OP_ISTG3} op_e;

    // Q1.14 constants; the H_ values carry the 1/2 orthonormal factor
    localparam samp_t K_C4  = 16'sd11585; // cos(pi/4)
    localparam samp_t K_H4  = 16'sd5793;  // cos(pi/4)/2
    localparam samp_t K_HC  = 16'sd7568;  // cos(pi/8)/2
    localparam samp_t K_HS  = 16'sd3135;  // sin(pi/8)/2
    localparam samp_t K_HC1 = 16'sd8035;  // cos(pi/16)/2
    localparam samp_t K_HC3 = 16'sd6811;  // cos(3pi/16)/2
    localparam samp_t K_HC5 = 16'sd4551;  // cos(5pi/16)/2
    localparam samp_t K_HC7 = 16'sd1598;  // cos(7pi/16)/2

    // two-term multiply-accumulate, round to nearest, wrap to 16 bits
    function automatic samp_t rot(samp_t x, samp_t cx, samp_t y, samp_t cy);
        logic signed [2*SAMP_W:0] acc;
        acc = x * cx + y * cy + (2*SAMP_W+1)'(1 << (FRAC_W - 1));
        return samp_t'(acc >>> FRAC_W);
    endfunction
endpackage

// File: rtl/dct2d_step.sv
module dct2d_step
    import dct2d_pkg::*;
(
    input  logic       inverse,
    input  logic [1:0] step,
    input  bank_t      regs_i,
    output bank_t      regs_o
);
    op_e op;

    always_comb begin
        unique case ({inverse, step})
            3'b000:  op = OP_BFLY;
            3'b001:  op = OP_STG2;
            3'b010:  op = OP_STG3;
            3'b011:  op = OP_ROT4;
            3'b100:  op = OP_IROT4;
            3'b101:  op = OP_ISTG3;
            3'b110:  op = OP_STG2;
            default: op = OP_BFLY;
        endcase
    end

    always_comb begin
        regs_o = regs_i;
        unique case (op)
            OP_BFLY: begin
                for (int k = 0; k < 4; k++) begin
                    regs_o[k]   = regs_i[k] + regs_i[7-k];
                    regs_o[7-k] = regs_i[k] - regs_i[7-k];
                end
            end
            OP_STG2: begin
                regs_o[0] = regs_i[0] + regs_i[3];
                regs_o[1] = regs_i[1] + regs_i[2];
                regs_o[2] = regs_i[1] - regs_i[2];
                regs_o[3] = regs_i[0] - regs_i[3];
                regs_o[5] = rot(regs_i[5], -K_C4, regs_i[6], K_C4);
                regs_o[6] = rot(regs_i[5],  K_C4, regs_i[6], K_C4);
            end
            OP_STG3: begin
                regs_o[0] = rot(regs_i[0], K_H4,  regs_i[1], K_H4);
                regs_o[4] = rot(regs_i[0], K_H4,  regs_i[1], -K_H4);
                regs_o[2] = rot(regs_i[2], K_HS,  regs_i[3], K_HC);
                regs_o[6] = rot(regs_i[2], -K_HC, regs_i[3], K_HS);
                regs_o[1] = regs_i[7] + regs_i[6];
                regs_o[3] = regs_i[7] - regs_i[6];
                regs_o[5] = regs_i[4] - regs_i[5];
                regs_o[7] = regs_i[4] + regs_i[5];
            end
            OP_ROT4: begin
                regs_o[1] = rot(regs_i[1], K_HC1, regs_i[7], K_HC7);
                regs_o[7] = rot(regs_i[1], K_HC7, regs_i[7], -K_HC1);
                regs_o[3] = rot(regs_i[3], K_HC3, regs_i[5], -K_HC5);
                regs_o[5] = rot(regs_i[3], K_HC5, regs_i[5], K_HC3);
            end
            OP_IROT4: begin
                regs_o[1] = rot(regs_i[1], K_HC1,  regs_i[7], K_HC7);
                regs_o[7] = rot(regs_i[1], K_HC7,  regs_i[7], -K_HC1);
                regs_o[3] = rot(regs_i[3], K_HC3,  regs_i[5], K_HC5);
                regs_o[5] = rot(regs_i[3], -K_HC5, regs_i[5], K_HC3);
            end
            OP_ISTG3: begin
                regs_o[0] = rot(regs_i[0], K_H4, regs_i[4], K_H4);
                regs_o[1] = rot(regs_i[0], K_H4, regs_i[4], -K_H4);
                regs_o[2] = rot(regs_i[2], K_HS, regs_i[6], -K_HC);
                regs_o[3] = rot(regs_i[2], K_HC, regs_i[6], K_HS);
                regs_o[7] = regs_i[1] + regs_i[3];
                regs_o[6] = regs_i[1] - regs_i[3];
                regs_o[4] = regs_i[5] + regs_i[7];
                regs_o[5] = regs_i[7] - regs_i[5];
            end
            default: regs_o = regs_i;
        endcase
    end
endmodule

// File: rtl/dct2d_addr.sv
module dct2d_addr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              is_col,
    input  logic              is_store,
    input  logic [2:0]        line,
    input  logic [2:0]        idx,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        be
);
    logic [5:0] off;

    always_comb begin
        unique case ({is_store, is_col})
            2'b00:   off = {line, idx};                 // row read, one sample per word
            2'b01:   off = {1'b0, idx[1:0], line};      // column read, two rows per word
            2'b10:   off = {1'b0, line[2:1], idx};      // row write, packed by row pair
            default: off = {idx, line};                 // column write, final tile
        endcase
        addr = base + ADDR_W'(off);
        if (!is_store)   be = 2'b00;
        else if (is_col) be = 2'b11;
        else             be = line[0] ? 2'b10 : 2'b01;
    end
endmodule

// File: rtl/dct2d_engine.sv
module dct2d_engine
    import dct2d_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              idct_mode,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [2*SAMP_W-1:0] mem_rdata,
    output logic [2*SAMP_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic              fin
);
    localparam int N_PTS     = 8;
    localparam int LAST      = N_PTS - 1;
    localparam int COL_LOADS = N_PTS / 2;
    localparam int STEPS     = 4;

    typedef struct packed {
        phase_e            st;
        logic              col;
        logic [2:0]        line;
        logic [2:0]        idx;
        logic              inv;
        logic [ADDR_W-1:0] base;
        bank_t             regs;
        logic              fin;
    } ctl_t;

    ctl_t  cur_q, nxt_d;
    bank_t step_out;
    samp_t out_s;
    logic  busy;
    logic [ADDR_W-1:0] base_lat;

    dct2d_step u_step (
        .inverse (cur_q.inv),
        .step    (cur_q.idx[1:0]),
        .regs_i  (cur_q.regs),
        .regs_o  (step_out)
    );

    dct2d_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base     (cur_q.base),
        .is_col   (cur_q.col),
        .is_store (cur_q.st == PH_STORE),
        .line     (cur_q.line),
        .idx      (cur_q.idx),
        .addr     (mem_addr),
        .be       (mem_be)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.fin = 1'b0;
        unique case (cur_q.st)
            PH_IDLE: begin
                if (start) begin
                    nxt_d.st   = PH_LOAD;
                    nxt_d.col  = 1'b0;
                    nxt_d.line = '0;
                    nxt_d.idx  = '0;
                    nxt_d.inv  = idct_mode;
                    nxt_d.base = base_addr;
                end
            end
            PH_LOAD: begin
                nxt_d.idx = cur_q.idx + 3'd1;
                if (!cur_q.col) begin
                    nxt_d.regs[cur_q.idx] = mem_rdata[SAMP_W-1:0];
                    if (cur_q.idx == 3'(LAST)) begin
                        nxt_d.st  = PH_CALC;
                        nxt_d.idx = '0;
                    end
                end else begin
                    nxt_d.regs[{cur_q.idx[1:0], 1'b0}] = mem_rdata[SAMP_W-1:0];
                    nxt_d.regs[{cur_q.idx[1:0], 1'b1}] = mem_rdata[2*SAMP_W-1:SAMP_W];
                    if (cur_q.idx == 3'(COL_LOADS - 1)) begin
                        nxt_d.st  = PH_CALC;
                        nxt_d.idx = '0;
                    end
                end
            end
            PH_CALC: begin
                nxt_d.regs = step_out;
                nxt_d.idx  = cur_q.idx + 3'd1;
                if (cur_q.idx == 3'(STEPS - 1)) begin
                    nxt_d.st  = PH_STORE;
                    nxt_d.idx = '0;
                end
            end
            PH_STORE: begin
                nxt_d.idx = cur_q.idx + 3'd1;
                if (cur_q.idx == 3'(LAST)) begin
                    nxt_d.idx = '0;
                    if (cur_q.line == 3'(LAST)) begin
                        if (cur_q.col) begin
                            nxt_d.st  = PH_IDLE;
                            nxt_d.fin = 1'b1;
                        end else begin
                            nxt_d.col  = 1'b1;
                            nxt_d.line = '0;
                            nxt_d.st   = PH_LOAD;
                        end
                    end else begin
                        nxt_d.line = cur_q.line + 3'd1;
                        nxt_d.st   = PH_LOAD;
                    end
                end
            end
            default: nxt_d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_s     = cur_q.regs[cur_q.idx];
    assign mem_we    = (cur_q.st == PH_STORE);
    assign mem_wdata = cur_q.col ? {{SAMP_W{out_s[SAMP_W-1]}}, out_s} : {out_s, out_s};
    assign fin       = cur_q.fin;
    assign busy      = (cur_q.st != PH_IDLE);
    assign base_lat  = cur_q.base;
endmodule

// File: rtl/dct2d_engine_chk.sv
module dct2d_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [ADDR_W-1:0] base_lat,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_we,
    input logic [1:0]        mem_be,
    input logic              fin
);
    p_fin_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
    p_fin_after_colstore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !mem_we && $past(mem_we) && $past(mem_be) == 2'b11);
    p_half_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be != 2'b11) |-> (mem_be == 2'b01 || mem_be == 2'b10)
                                         && mem_wdata[31:16] == mem_wdata[15:0]);
    p_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == 2'b11) |-> mem_wdata[31:16] == {16{mem_wdata[15]}});
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);
    p_tile_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_addr - base_lat) < ADDR_W'(64));
    p_base_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(base_lat));
endmodule

bind dct2d_engine dct2d_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .base_lat  (base_lat),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .fin       (fin)
);

// File: tb/dct2d_engine_bench.sv
`timescale 1ns/1ps
module dct2d_engine_bench;
    localparam real PI  = 3.14159265358979;
    localparam int  TOL = 5;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, idct_mode = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_we, fin;
    logic [1:0]  mem_be;
    logic [31:0] mem [0:127];
    logic [31:0] seed = 32'h1234_5678;
    int  checks = 0, errors = 0;
    bit  done = 0;
    int  q_kind[$], q_addr[$], q_be[$];
    real ref_in[64], ref_out[64];

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[6:0]];
    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_be[0]) mem[mem_addr[6:0]][15:0]  <= mem_wdata[15:0];
            if (mem_be[1]) mem[mem_addr[6:0]][31:16] <= mem_wdata[31:16];
        end
    end

    dct2d_engine u_dct2d_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .idct_mode(idct_mode),
        .base_addr(base_addr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_be(mem_be), .fin(fin)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]) - 128;
    endfunction

    function automatic real basis(int k, int n);
        real s = (k == 0) ? 1.0 / $sqrt(2.0) : 1.0;
        return s * $cos((2 * n + 1) * k * PI / 16.0) / 2.0;
    endfunction

    // pattern: 0 constant, 1 random, 2 ramp, 3 DC only, 4 random small
    task automatic run(bit inv, int base, int pattern, bit disturb);
        string rq = inv ? "R8" : "R7";
        for (int e = 0; e < 64; e++) begin
            int v;
            case (pattern)
                0: v = 100;
                1: v = rnd();
                2: v = (e / 8) * 9 - (e % 8) * 7;
                3: v = (e == 0) ? 800 : 0;
                default: v = rnd() / 2;
            endcase
            ref_in[e] = v;
            mem[base + e] = {16'hA5C3 ^ 16'(e * 77), 16'(v)};
        end
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                real s = 0.0;
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        s += inv ? basis(i, a) * basis(j, b) * ref_in[i*8+j]
                                 : basis(a, i) * basis(b, j) * ref_in[i*8+j];
                ref_out[a*8+b] = s;
            end
        // expected bus schedule: kind 0 read, 1 compute, 2 write
        q_kind.delete(); q_addr.delete(); q_be.delete();
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin q_kind.push_back(0); q_addr.push_back(base + 8*r + c); q_be.push_back(0); end
            for (int s = 0; s < 4; s++) begin q_kind.push_back(1); q_addr.push_back(0); q_be.push_back(0); end
            for (int k = 0; k < 8; k++) begin q_kind.push_back(2); q_addr.push_back(base + 8*(r/2) + k); q_be.push_back((r % 2) ? 2 : 1); end
        end
        for (int c = 0; c < 8; c++) begin
            for (int j = 0; j < 4; j++) begin q_kind.push_back(0); q_addr.push_back(base + 8*j + c); q_be.push_back(0); end
            for (int s = 0; s < 4; s++) begin q_kind.push_back(1); q_addr.push_back(0); q_be.push_back(0); end
            for (int k = 0; k < 8; k++) begin q_kind.push_back(2); q_addr.push_back(base + 8*k + c); q_be.push_back(3); end
        end
        chk(q_kind.size() == 288, "R9", "schedule length", q_kind.size(), 288);
        @(negedge clk);
        start = 1'b1; idct_mode = inv; base_addr = base;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; q_kind.size() > 0; n++) begin
            int kd = q_kind.pop_front();
            int ea = q_addr.pop_front();
            int eb = q_be.pop_front();
            chk(fin == 1'b0, "R9", "fin early", fin, 0);
            if (kd == 0) chk(!mem_we && mem_addr == 32'(ea), "R2/R5", "read addr", mem_addr, ea);
            else if (kd == 1) chk(!mem_we, "R3", "compute cycle we", mem_we, 0);
            else chk(mem_we && mem_addr == 32'(ea) && mem_be == 2'(eb),
                     "R4/R6", "write addr*4+be", longint'(mem_addr) * 4 + mem_be, ea * 4 + eb);
            if (disturb && n == 40) begin start = 1'b1; idct_mode = !inv; base_addr = base ^ 64; end
            if (disturb && n == 41) start = 1'b0;
            @(negedge clk);
        end
        chk(fin == 1'b1 && mem_we == 1'b0, "R9", "fin after last store", fin, 1);
        @(negedge clk);
        chk(fin == 1'b0, "R9", "fin width", fin, 0);
        for (int w = 0; w < 4; w++) begin
            chk(!mem_we && !fin, "R10", "no restart after fin", mem_we, 0);
            @(negedge clk);
        end
        for (int e = 0; e < 64; e++) begin
            int got = int'($signed(mem[base + e][15:0]));
            int exp = int'(ref_out[e]);
            int d   = got - exp;
            if (d < 0) d = -d;
            chk(d <= TOL, disturb ? {rq, "/R11"} : rq, "coefficient", got, exp);
            chk(mem[base + e][31:16] == {16{mem[base + e][15]}}, "R6", "sign extension",
                mem[base + e][31:16], {16{mem[base + e][15]}});
        end
        idct_mode = 1'b0; base_addr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(fin == 1'b0 && mem_we == 1'b0, "R1", "reset outputs", {fin, mem_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(fin == 1'b0 && mem_we == 1'b0, "R1", "idle after reset", {fin, mem_we}, 0);
        run(1'b0, 0,  0, 1'b0);   // flat tile, DC only result
        run(1'b0, 64, 1, 1'b1);   // random tile, mid-run start/base/mode change
        run(1'b0, 0,  2, 1'b0);   // ramp tile
        run(1'b1, 64, 3, 1'b0);   // inverse of DC only
        run(1'b1, 0,  4, 1'b1);   // random coefficients, disturbed
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule